// File: doc/BRIEF.md
# VGA horizontal line and pixel burst

This block produces the horizontal side of a VGA-style raster. A free-running counter measures one line period and wraps at a limit set on an input port. The wrap is the start of a line. On that wrap, if the vertical controller holds the pixel-enable input high, the block runs a burst of a fixed number of reads from a line-buffer read port. The read port has a latency of one cycle. Each returned byte goes straight to the 8-bit colour output. Once the last byte has been shown, the block writes a single zero to the colour output, so the rest of the line is black.

The horizontal sync output is set by two compare values on the same counter. The output returns high when the count meets the sync-end value and drops low when it meets the sync-start value, which gives an active-low pulse. When the compare values are placed after the burst, the pulse falls outside the visible pixels. A one-cycle line-event strobe, taken from the sync-start compare, advances the vertical controller once per line. The read base address is captured when a burst begins, so a change to it takes effect on the next line.

Top module: `hline_burst`

## Requirements
- R1: The line counter counts from 0 up to `line_max` and then returns to 0. Consecutive `line_event` pulses are therefore `line_max`+1 cycles apart.
- R2: When the counter equals `line_max` at a clock edge and `pix_en` is high, the block issues LINE_LEN read requests (`rd_en` high) on consecutive cycles, starting the cycle after that edge. The addresses are base, base+1, …, base+LINE_LEN-1, modulo 2^ADDR_W.
- R3: The read data returns one cycle after its request. Each byte appears on `pix_out` for exactly one cycle, two cycles after its request, in request order.
- R4: In the cycle after the last byte of a burst, `pix_out` becomes 0, and it stays 0 until the next burst delivers data.
- R5: `hsync` goes high the cycle after the count equals `hs_end`, and goes low the cycle after the count equals `hs_start`. If both values match the count, high wins. Otherwise `hsync` holds its level.
- R6: `line_event` is high for exactly the one cycle after the count equals `hs_start`, once per line.
- R7: If `pix_en` is low at the wrap edge, that line issues no read request and `pix_out` stays 0.
- R8: `src_base` is sampled only at the burst start edge. A change during a burst has no effect on the burst in progress and is used from the next burst on.
- R9: While `rst_n` is low, and for the two cycles of synchronous release after it, the block holds `pix_out` at 0, `hsync` at 1, and `line_event` and `rd_en` at 0. The counter restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_max | input | CNT_W | Last count value of a line (period minus one) |
| hs_start | input | CNT_W | Count at which hsync falls and the line event fires |
| hs_end | input | CNT_W | Count at which hsync rises |
| pix_en | input | 1 | Vertical controller: send pixels on the next line |
| src_base | input | ADDR_W | Line-buffer address of the first pixel of a line |
| rd_en | output | 1 | Line-buffer read request |
| rd_addr | output | ADDR_W | Line-buffer read address |
| rd_data | input | PIX_W | Read data, valid one cycle after the request |
| pix_out | output | PIX_W | Colour output byte |
| hsync | output | 1 | Horizontal sync, active low |
| line_event | output | 1 | One-cycle strobe per line for the vertical controller |

## Verification
The bench builds the block with its default parameters: 16-bit counter and address, 8-bit pixels and a full 160-byte burst. The full burst makes the blanking write and the placement of hsync after the burst visible exactly as they would be in use. The line limit is driven at 199 and then 229, so many complete lines fit into a short run, and the change of limit shows up in the line-event spacing. A base address of 0xFFC0 makes the burst cross the top of the 16-bit address space. Equal sync-start and sync-end values exercise the tie rule of the sync compare.

// File: rtl/hl_pkg.sv
package hl_pkg;
  typedef enum logic {
    BURST_IDLE = 1'b0,
    BURST_RUN  = 1'b1
  } burst_state_t;

  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/hl_line_counter.sv
module hl_line_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap_o = (cnt_q == limit_i);

  always_comb begin
    if (wrap_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hl_hsync_cmp.sv
module hl_hsync_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             hsync_o,
  output logic             evt_o
);
  logic hs_q, hs_d, evt_q, evt_d;
  logic hit_start, hit_end;

  assign hit_start = (cnt_i == start_i);
  assign hit_end   = (cnt_i == end_i);

  always_comb begin
    hs_d = hs_q;
    if (hit_end)        hs_d = 1'b1;
    else if (hit_start) hs_d = 1'b0;
    evt_d = hit_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b1;
      evt_q <= 1'b0;
    end else begin
      hs_q  <= hs_d;
      evt_q <= evt_d;
    end
  end

  assign hsync_o = hs_q;
  assign evt_o   = evt_q;

  // R5
  hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == end_i) |=> hsync_o);

  // R5
  hs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == start_i && cnt_i != end_i) |=> !hsync_o);
endmodule

// File: rtl/hl_burst_seq.sv
module hl_burst_seq
  import hl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LINE_LEN = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              last_o
);
  localparam int unsigned IDX_W = $clog2(LINE_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LINE_LEN - 1);

  burst_state_t      st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q;
  logic              base_en;
  logic              last_q, last_d;
  logic              at_last;

  assign at_last = (st_q == BURST_RUN) && (idx_q == IDX_LAST);
  assign base_en = start_i;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    last_d = at_last;
    if (start_i) begin
      st_d  = BURST_RUN;
      idx_d = '0;
    end else if (st_q == BURST_RUN) begin
      if (at_last) begin
        st_d  = BURST_IDLE;
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BURST_IDLE;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_i;
  end

  assign rd_en_o   = (st_q == BURST_RUN);
  assign rd_addr_o = base_q + ADDR_W'(idx_q);
  assign last_o    = last_q;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o) && !$past(start_i))
      |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && !start_i) |=> (rd_en_o -> rd_addr_o == $past(rd_addr_o) + 1'b1));
endmodule

// File: rtl/hl_pixel_out.sv
module hl_pixel_out #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic             last_i,
  input  logic [PIX_W-1:0] rd_data_i,
  output logic [PIX_W-1:0] pix_o
);
  logic             valid_q, zero_q;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             pix_en;

  assign pix_en = valid_q | zero_q;

  always_comb begin
    pix_d = '0;
    if (valid_q) pix_d = rd_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      zero_q  <= last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pix_q <= '0;
    else if (pix_en) pix_q <= pix_d;
  end

  assign pix_o = pix_q;

  // R4
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |=> (pix_o == '0));
endmodule

// File: rtl/hline_burst.sv
module hline_burst
  import hl_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned LINE_LEN = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  line_max,
  input  logic [CNT_W-1:0]  hs_start,
  input  logic [CNT_W-1:0]  hs_end,
  input  logic              pix_en,
  input  logic [ADDR_W-1:0] src_base,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic [PIX_W-1:0]  pix_out,
  output logic              hsync,
  output logic              line_event
);
  logic [RST_SYNC_STAGES-1:0] rs_q;
  logic                       srst_n;
  logic [CNT_W-1:0]           cnt_w;
  logic                       wrap_w, start_w, last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rs_q[RST_SYNC_STAGES-1];

  hl_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .limit_i(line_max),
    .cnt_o(cnt_w), .wrap_o(wrap_w)
  );

  hl_hsync_cmp #(.CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst_n(srst_n), .cnt_i(cnt_w),
    .start_i(hs_start), .end_i(hs_end),
    .hsync_o(hsync), .evt_o(line_event)
  );

  assign start_w = wrap_w & pix_en;

  hl_burst_seq #(.ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN)) u_seq (
    .clk(clk), .rst_n(srst_n), .start_i(start_w), .base_i(src_base),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .last_o(last_w)
  );

  hl_pixel_out #(.PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst_n(srst_n), .rd_en_i(rd_en), .last_i(last_w),
    .rd_data_i(rd_data), .pix_o(pix_out)
  );

  // R7
  no_burst_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wrap_w && !pix_en && !rd_en) |=> !rd_en);

  // R6
  evt_once_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (line_event && line_max != '0) |=> !line_event);
endmodule

// File: tb/hline_burst_tb.sv
`timescale 1ns/1ps
module hline_burst_tb;
  localparam int LEN = 160;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] line_max, hs_start, hs_end, src_base, rd_addr;
  logic        pix_en, rd_en, hsync, line_event;
  logic [7:0]  rd_data, pix_out;

  always #2 clk = ~clk;

  hline_burst u_dut (
    .clk(clk), .rst_n(rst_n), .line_max(line_max), .hs_start(hs_start),
    .hs_end(hs_end), .pix_en(pix_en), .src_base(src_base), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_out(pix_out), .hsync(hsync),
    .line_event(line_event)
  );

  function automatic int memf(int a);
    return (a * 37 + 11) & 255;
  endfunction

  initial rd_data = 8'h00;
  always @(posedge clk) if (rd_en) rd_data <= 8'(memf(int'(rd_addr)));

  int vectors = 0, fails = 0;
  int edge_n = 0, rel = 0, mcnt = 0, bidx = -1, bbase = 0;
  int exp_pix = 0, exp_hs = 1, exp_evt = 0, exp_rd = 0, exp_addr = 0;
  int sched[int];
  int epoch = 0, last_evt = -1, last_epoch = -1;
  bit done = 0;

  // reference model: state after each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; mcnt = 0; bidx = -1; exp_pix = 0; exp_hs = 1;
      exp_evt = 0; exp_rd = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      if (sched.exists(edge_n)) exp_pix = sched[edge_n];
      if (mcnt == int'(hs_end)) exp_hs = 1;
      else if (mcnt == int'(hs_start)) exp_hs = 0;
      exp_evt = (mcnt == int'(hs_start));
      if (mcnt == int'(line_max) && pix_en) begin
        bidx = 0; bbase = int'(src_base);
      end else if (bidx >= 0) begin
        bidx = (bidx == LEN - 1) ? -1 : bidx + 1;
      end
      if (bidx >= 0) begin
        exp_rd = 1;
        exp_addr = (bbase + bidx) & 16'hFFFF;
        sched[edge_n + 2] = memf(exp_addr);
        if (bidx == LEN - 1) sched[edge_n + 3] = 0;
      end else begin
        exp_rd = 0;
      end
      mcnt = (mcnt == int'(line_max)) ? 0 : mcnt + 1;
    end
    edge_n++;
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %0d expected %0d", req, what, edge_n, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (edge_n >= 1 && !done) begin
      chk("R3 R4 R7 R9", "pix_out", int'(pix_out), exp_pix);
      chk("R5 R9", "hsync", int'(hsync), exp_hs);
      chk("R6 R9", "line_event", int'(line_event), exp_evt);
      chk("R2 R7 R9", "rd_en", int'(rd_en), exp_rd);
      if (exp_rd == 1) chk("R2 R8", "rd_addr", int'(rd_addr), exp_addr);
      if (line_event === 1'b1) begin
        if (last_evt >= 0 && last_epoch == epoch)
          chk("R1", "line period", edge_n - last_evt, int'(line_max) + 1);
        last_evt = edge_n; last_epoch = epoch;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (edge_n > 100000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired: actual %0d expected below %0d", edge_n, 100000);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; line_max = 16'd199; hs_start = 16'd170; hs_end = 16'd180;
    pix_en = 1'b1; src_base = 16'h1000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (650) @(negedge clk);
    // R8: base changed in the middle of a line
    repeat (20) @(negedge clk);
    src_base = 16'h2000;
    repeat (400) @(negedge clk);
    // R7: pixels disabled
    pix_en = 1'b0;
    repeat (500) @(negedge clk);
    // new geometry, address wrap at top of space
    pix_en = 1'b1; src_base = 16'hFFC0;
    hs_start = 16'd185; hs_end = 16'd195; line_max = 16'd229; epoch++;
    repeat (700) @(negedge clk);
    // R5 tie: equal compare values
    hs_start = 16'd195; hs_end = 16'd195; epoch++;
    repeat (500) @(negedge clk);
    done = 1;
    summary();
  end
endmodule